// File: doc/BRIEF.md
# Adder-Subtractor with Condition Flags and Comparison Decode

This block is a purely combinational arithmetic unit for two operands of a parameterised width. The default width is 8 bits. One select input chooses between sum and difference. For a difference the unit inverts the second operand bit by bit and forces the adder's carry-in high. That way a single carry network handles both operations with two's complement negation. The adder splits its bits into groups of a parameterised size. Each group forms its own block generate and propagate terms, and group carries pass from group to group on those terms.

Next to the N-bit result the unit drives four condition flags: zero, negative, carry-out and signed overflow. A decode stage turns those four flags alone into ten ordering outcomes: equality, four signed relations and four unsigned relations. These outcomes are meaningful only when the select asks for a difference of A and B. In the add setting they are still driven, but they carry no defined meaning. A typical use is a branch-condition or compare path that already owns a subtractor.

There is no clock and no state. Every output follows the inputs through logic only.

Top module: `addsub_cmp_unit`

## Requirements
- R1: With `sub_sel` = 0, `result` equals (A + B) mod 2^WIDTH and `flag_carry` equals bit WIDTH of the full unsigned sum.
- R2: With `sub_sel` = 1, `result` equals (A − B) mod 2^WIDTH, formed as A + ~B + 1. `flag_carry` is the carry-out of that addition, so it is 1 exactly when A ≥ B as unsigned values.
- R3: `flag_zero` is 1 exactly when every bit of `result` is 0.
- R4: `flag_neg` equals the most significant bit of `result`.
- R5: `flag_ovf` is 1 exactly when A and the operand actually fed to the adder (B, or ~B when subtracting) have equal sign bits and the sign bit of `result` differs from them. This is the same as the true signed sum or difference falling outside the two's complement range.
- R6: With `sub_sel` = 1, the signed relations follow from lt = N xor V. `cmp_lt` = lt, `cmp_le` = lt or Z, `cmp_ge` = not lt, and `cmp_gt` = not (lt or Z). Each matches the signed ordering of A and B.
- R7: With `sub_sel` = 1, `cmp_eq` = Z and `cmp_ne` = not Z, so they show whether A equals B.
- R8: With `sub_sel` = 1, the unsigned relations come from the carry flag C and Z. `cmp_ltu` = not C, `cmp_leu` = (not C) or Z, `cmp_geu` = C, and `cmp_gtu` = C and not Z. Each matches the unsigned ordering of A and B.
- R9: Every output is a function of the present inputs alone. Corner operands (0, all ones, most-negative, most-positive) give the same flag behaviour as any other operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sub_sel | input | 1 | 0 = add, 1 = subtract op_b from op_a |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| flag_zero | output | 1 | Result is all zeros |
| flag_neg | output | 1 | Result sign bit |
| flag_carry | output | 1 | Carry out of the top adder position |
| flag_ovf | output | 1 | Signed overflow |
| cmp_eq | output | 1 | A equals B (subtract mode) |
| cmp_ne | output | 1 | A differs from B (subtract mode) |
| cmp_lt | output | 1 | A < B signed (subtract mode) |
| cmp_le | output | 1 | A ≤ B signed (subtract mode) |
| cmp_gt | output | 1 | A > B signed (subtract mode) |
| cmp_ge | output | 1 | A ≥ B signed (subtract mode) |
| cmp_ltu | output | 1 | A < B unsigned (subtract mode) |
| cmp_leu | output | 1 | A ≤ B unsigned (subtract mode) |
| cmp_gtu | output | 1 | A > B unsigned (subtract mode) |
| cmp_geu | output | 1 | A ≥ B unsigned (subtract mode) |

## Verification
No register lies between the inputs and any output. The result, the four flags and the ten ordering outcomes are therefore all due in the same cycle the operands and select are applied, zero clock edges later. The bench changes the inputs just after a rising edge and reads every output at the following falling edge, half a period later. Nothing is read at an edge where the inputs move. A 6-bit instance is swept over every operand pair in both modes, and each output is compared with values worked out in wider signed and unsigned integer arithmetic.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef struct packed {
        logic zero;
        logic neg;
        logic carry;
        logic ovf;
    } cc_flags_t;

    typedef struct packed {
        logic eq;
        logic ne;
        logic lt;
        logic le;
        logic gt;
        logic ge;
        logic ltu;
        logic leu;
        logic gtu;
        logic geu;
    } cmp_set_t;

endpackage

// File: rtl/addsub_pg_cells.sv
module addsub_pg_cells #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             invert_b,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);
    logic [WIDTH-1:0] b_fed;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            assign b_fed[i] = opnd_b[i] ^ invert_b;
            assign gen[i]   = opnd_a[i] & b_fed[i];
            assign prop[i]  = opnd_a[i] ^ b_fed[i];
        end
    endgenerate
endmodule

// File: rtl/addsub_block_carry.sv
module addsub_block_carry #(
    parameter int WIDTH   = 8,
    parameter int GROUP_W = 4
) (
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] prop,
    input  logic             carry_in,
    output logic [WIDTH:0]   carry
);
    localparam int NUM_GRP = (WIDTH + GROUP_W - 1) / GROUP_W;

    logic [NUM_GRP-1:0] grp_g;
    logic [NUM_GRP-1:0] grp_p;
    logic [NUM_GRP:0]   grp_c;

    // carries between groups use block generate/propagate only
    always_comb begin
        grp_c[0] = carry_in;
        for (int k = 0; k < NUM_GRP; k++) begin
            grp_c[k+1] = grp_g[k] | (grp_p[k] & grp_c[k]);
        end
    end

    genvar k;
    generate
        for (k = 0; k < NUM_GRP; k++) begin : g_grp
            localparam int LO   = k * GROUP_W;
            localparam int SPAN = ((WIDTH - LO) < GROUP_W) ? (WIDTH - LO) : GROUP_W;

            logic            blk_g;
            logic            blk_p;
            logic [SPAN-1:0] loc_c;

            always_comb begin
                blk_g = 1'b0;
                blk_p = 1'b1;
                for (int i = 0; i < SPAN; i++) begin
                    blk_g = gen[LO+i] | (prop[LO+i] & blk_g);
                    blk_p = blk_p & prop[LO+i];
                end
                loc_c[0] = grp_c[k];
                for (int i = 0; i < SPAN - 1; i++) begin
                    loc_c[i+1] = gen[LO+i] | (prop[LO+i] & loc_c[i]);
                end
            end

            assign grp_g[k]         = blk_g;
            assign grp_p[k]         = blk_p;
            assign carry[LO +: SPAN] = loc_c;
        end
    endgenerate

    assign carry[WIDTH] = grp_c[NUM_GRP];
endmodule

// File: rtl/addsub_flag_decode.sv
module addsub_flag_decode
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] sum_bits,
    input  logic             carry_top,
    input  logic             carry_msb,
    output cc_flags_t        flags,
    output cmp_set_t         cmps
);
    logic lt_signed;

    always_comb begin
        flags.zero  = ~|sum_bits;
        flags.neg   = sum_bits[WIDTH-1];
        flags.carry = carry_top;
        flags.ovf   = carry_top ^ carry_msb;
    end

    assign lt_signed = flags.neg ^ flags.ovf;

    always_comb begin
        cmps.eq  = flags.zero;
        cmps.ne  = ~flags.zero;
        cmps.lt  = lt_signed;
        cmps.le  = lt_signed | flags.zero;
        cmps.ge  = ~lt_signed;
        cmps.gt  = ~(lt_signed | flags.zero);
        cmps.ltu = ~flags.carry;
        cmps.leu = ~flags.carry | flags.zero;
        cmps.geu = flags.carry;
        cmps.gtu = flags.carry & ~flags.zero;
    end
endmodule

// File: rtl/addsub_cmp_unit.sv
module addsub_cmp_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int GROUP_W = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_sel,
    output logic [WIDTH-1:0] result,
    output logic             flag_zero,
    output logic             flag_neg,
    output logic             flag_carry,
    output logic             flag_ovf,
    output logic             cmp_eq,
    output logic             cmp_ne,
    output logic             cmp_lt,
    output logic             cmp_le,
    output logic             cmp_gt,
    output logic             cmp_ge,
    output logic             cmp_ltu,
    output logic             cmp_leu,
    output logic             cmp_gtu,
    output logic             cmp_geu
);
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    logic [WIDTH:0]   carry;
    cc_flags_t        flags;
    cmp_set_t         cmps;

    addsub_pg_cells #(.WIDTH(WIDTH)) u_pg (
        .opnd_a   (op_a),
        .opnd_b   (op_b),
        .invert_b (sub_sel),
        .gen      (gen),
        .prop     (prop)
    );

    addsub_block_carry #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) u_carry (
        .gen      (gen),
        .prop     (prop),
        .carry_in (sub_sel),
        .carry    (carry)
    );

    assign result = prop ^ carry[WIDTH-1:0];

    addsub_flag_decode #(.WIDTH(WIDTH)) u_flags (
        .sum_bits  (result),
        .carry_top (carry[WIDTH]),
        .carry_msb (carry[WIDTH-1]),
        .flags     (flags),
        .cmps      (cmps)
    );

    assign flag_zero  = flags.zero;
    assign flag_neg   = flags.neg;
    assign flag_carry = flags.carry;
    assign flag_ovf   = flags.ovf;
    assign cmp_eq     = cmps.eq;
    assign cmp_ne     = cmps.ne;
    assign cmp_lt     = cmps.lt;
    assign cmp_le     = cmps.le;
    assign cmp_gt     = cmps.gt;
    assign cmp_ge     = cmps.ge;
    assign cmp_ltu    = cmps.ltu;
    assign cmp_leu    = cmps.leu;
    assign cmp_gtu    = cmps.gtu;
    assign cmp_geu    = cmps.geu;
endmodule

// File: rtl/addsub_cmp_checker.sv
module addsub_cmp_checker #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sub_sel,
    input logic [WIDTH-1:0] result,
    input logic             flag_zero,
    input logic             flag_neg,
    input logic             flag_carry,
    input logic             flag_ovf,
    input logic             cmp_eq,
    input logic             cmp_ne,
    input logic             cmp_lt,
    input logic             cmp_le,
    input logic             cmp_gt,
    input logic             cmp_ge,
    input logic             cmp_ltu,
    input logic             cmp_leu,
    input logic             cmp_gtu,
    input logic             cmp_geu
);
    logic [WIDTH-1:0] b_seen;
    logic [WIDTH:0]   wide_sum;

    assign b_seen   = sub_sel ? ~op_b : op_b;
    assign wide_sum = {1'b0, op_a} + {1'b0, b_seen} + {{WIDTH{1'b0}}, sub_sel};

    always_comb begin
        if (!$isunknown({op_a, op_b, sub_sel})) begin
            assert_sum_carry_R1: assert ({flag_carry, result} == wide_sum)
                else $error("sum/carry mismatch");
            assert_borrow_sense_R2: assert (!sub_sel || (flag_carry == (op_a >= op_b)))
                else $error("subtract carry sense wrong");
            assert_zero_flag_R3: assert (flag_zero == (result == '0))
                else $error("zero flag wrong");
            assert_neg_flag_R4: assert (flag_neg == result[WIDTH-1])
                else $error("negative flag wrong");
            assert_no_overflow_R5: assert (flag_ovf ==
                    ((op_a[WIDTH-1] == b_seen[WIDTH-1]) && (result[WIDTH-1] != op_a[WIDTH-1])))
                else $error("overflow flag wrong");
            assert_signed_order_R6: assert (!sub_sel ||
                    ((cmp_lt == ($signed(op_a) < $signed(op_b))) &&
                     (cmp_le == ($signed(op_a) <= $signed(op_b))) &&
                     (cmp_gt == ($signed(op_a) > $signed(op_b))) &&
                     (cmp_ge == ($signed(op_a) >= $signed(op_b)))))
                else $error("signed ordering wrong");
            assert_equality_R7: assert (!sub_sel ||
                    ((cmp_eq == (op_a == op_b)) && (cmp_ne == (op_a != op_b))))
                else $error("equality wrong");
            assert_unsigned_order_R8: assert (!sub_sel ||
                    ((cmp_ltu == (op_a < op_b)) && (cmp_leu == (op_a <= op_b)) &&
                     (cmp_gtu == (op_a > op_b)) && (cmp_geu == (op_a >= op_b))))
                else $error("unsigned ordering wrong");
        end
    end
endmodule

bind addsub_cmp_unit addsub_cmp_checker #(.WIDTH(WIDTH)) i_addsub_chk (
    .op_a       (op_a),
    .op_b       (op_b),
    .sub_sel    (sub_sel),
    .result     (result),
    .flag_zero  (flag_zero),
    .flag_neg   (flag_neg),
    .flag_carry (flag_carry),
    .flag_ovf   (flag_ovf),
    .cmp_eq     (cmp_eq),
    .cmp_ne     (cmp_ne),
    .cmp_lt     (cmp_lt),
    .cmp_le     (cmp_le),
    .cmp_gt     (cmp_gt),
    .cmp_ge     (cmp_ge),
    .cmp_ltu    (cmp_ltu),
    .cmp_leu    (cmp_leu),
    .cmp_gtu    (cmp_gtu),
    .cmp_geu    (cmp_geu)
);

// File: tb/test_addsub_cmp_unit.sv
module test_addsub_cmp_unit;
    localparam int W    = 6;
    localparam int GW   = 4;
    localparam int SPAN = 1 << W;
    localparam int HALF = 1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub_sel = 1'b0;
    logic [W-1:0] result;
    logic flag_zero, flag_neg, flag_carry, flag_ovf;
    logic cmp_eq, cmp_ne, cmp_lt, cmp_le, cmp_gt, cmp_ge;
    logic cmp_ltu, cmp_leu, cmp_gtu, cmp_geu;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    addsub_cmp_unit #(.WIDTH(W), .GROUP_W(GW)) i_addsub_cmp_unit (
        .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel), .result(result),
        .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_carry(flag_carry), .flag_ovf(flag_ovf),
        .cmp_eq(cmp_eq), .cmp_ne(cmp_ne), .cmp_lt(cmp_lt), .cmp_le(cmp_le),
        .cmp_gt(cmp_gt), .cmp_ge(cmp_ge), .cmp_ltu(cmp_ltu), .cmp_leu(cmp_leu),
        .cmp_gtu(cmp_gtu), .cmp_geu(cmp_geu)
    );

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s a=%0d b=%0d sub=%0d actual=%0d expected=%0d",
                     tag, op_a, op_b, sub_sel, actual, expected);
        end
    endtask

    function automatic int to_signed(input int v);
        return (v >= HALF) ? v - SPAN : v;
    endfunction

    task automatic apply_and_check(input int a, input int b, input bit sub);
        int sa, sb, b_fed, full, exp_res, exp_cy, true_val;
        @(posedge clk);
        #1;
        op_a    = W'(a);
        op_b    = W'(b);
        sub_sel = sub;
        @(negedge clk);
        b_fed    = sub ? ((~b) & (SPAN - 1)) : b;
        full     = a + b_fed + int'(sub);
        exp_res  = full % SPAN;
        exp_cy   = full / SPAN;
        sa       = to_signed(a);
        sb       = to_signed(b);
        true_val = sub ? sa - sb : sa + sb;
        if (sub) begin
            check("R2 result", int'(result), exp_res);
            check("R2 carry", int'(flag_carry), exp_cy);
            check("R2 carry means a>=b", int'(flag_carry), int'(a >= b));
        end else begin
            check("R1 result", int'(result), exp_res);
            check("R1 carry", int'(flag_carry), exp_cy);
        end
        check("R3 zero", int'(flag_zero), int'(exp_res == 0));
        check("R4 neg", int'(flag_neg), int'(exp_res >= HALF));
        check("R5 ovf", int'(flag_ovf), int'(true_val >= HALF || true_val < -HALF));
        if (sub) begin
            check("R6 lt", int'(cmp_lt), int'(sa < sb));
            check("R6 le", int'(cmp_le), int'(sa <= sb));
            check("R6 gt", int'(cmp_gt), int'(sa > sb));
            check("R6 ge", int'(cmp_ge), int'(sa >= sb));
            check("R7 eq", int'(cmp_eq), int'(a == b));
            check("R7 ne", int'(cmp_ne), int'(a != b));
            check("R8 ltu", int'(cmp_ltu), int'(a < b));
            check("R8 leu", int'(cmp_leu), int'(a <= b));
            check("R8 gtu", int'(cmp_gtu), int'(a > b));
            check("R8 geu", int'(cmp_geu), int'(a >= b));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // idle state: zero operands in add mode
        @(negedge clk);
        check("R3 idle zero", int'(flag_zero), 1);
        check("R1 idle result", int'(result), 0);
        // R9 corner operands first, then an exhaustive sweep of both modes
        apply_and_check(HALF - 1, 1, 1'b0);
        apply_and_check(HALF, 1, 1'b1);
        apply_and_check(SPAN - 1, SPAN - 1, 1'b0);
        apply_and_check(0, HALF, 1'b1);
        apply_and_check(HALF, HALF - 1, 1'b1);
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < SPAN; a++) begin
                for (int b = 0; b < SPAN; b++) begin
                    apply_and_check(a, b, s[0]);
                end
            end
        end
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule